// File: doc/BRIEF.md
# Multi-Rate Nibble-Parallel BCH Encoder

This block is a systematic binary BCH encoder. It takes message bits four per clock and works out the parity bits by dividing the message polynomial by a generator polynomial. A rate code given with the first nibble of a block picks one of three built-in generator polynomials. Each polynomial is the product of the minimal polynomials that define its code, so one circuit serves every supported code. The divider is a remainder register that looks ahead four bits per cycle. Each clock it absorbs a whole nibble of the dividend.

The block is used as a stream stage. The source marks the first nibble of a block with a start strobe together with the valid strobe. It then supplies the remaining message nibbles, and it may leave idle cycles between them. Every message nibble comes out one cycle later, unchanged. The parity nibbles follow directly after the last message nibble, highest-order bit first. While parity is being emitted the source must hold its valid input low.

Top module: `bchEnc`

## Requirements
- R1: A block starts when `sopIn` and `validIn` are high together while the encoder is idle. `rateIn` is sampled in that cycle. The rate codes are as follows. Code 0 selects g(x)=x^4+x+1, with 8 message bits and 4 parity bits. Code 1 selects g(x)=x^8+x^7+x^6+x^4+1, with 4 message bits and 8 parity bits. Code 2 selects g(x)=x^12+x^10+x^8+x^5+x^4+x^3+1, with 48 message bits and 12 parity bits. Code 3 must not be presented with a start.
- R2: Each accepted message nibble appears unchanged on `dataOut` one clock after it was accepted, with `validOut` high. Bit 3 of a nibble is the earliest bit of the message polynomial, which is the highest-order term.
- R3: The parity is the remainder of m(x)·x^p divided by g(x), where p is the parity length. It is emitted as p/4 nibbles, most significant bit first, with `validOut` high. The parity nibbles occupy the cycles directly after the last message nibble appears, with no gap.
- R4: Every emitted codeword, the message followed by its parity, read as one polynomial, is divisible by its generator polynomial.
- R5: During a block, a cycle with `validIn` low is ignored. It produces no output (`validOut` low), and it leaves the division unchanged whatever `dataIn` holds.
- R6: Changes on `rateIn` after the start cycle of a block have no effect on that block.
- R7: The remainder restarts from zero at every block start, so equal messages give equal parity whatever came before.
- R8: While idle, a valid nibble without `sopIn` is ignored: `validOut` stays low.
- R9: After reset the encoder is idle and `validOut` is low.
- R10: `validIn` must stay low while parity is being emitted, and `sopIn` may only be raised while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sopIn | input | 1 | First nibble of a block (with validIn) |
| validIn | input | 1 | dataIn holds a message nibble |
| rateIn | input | 2 | Code select, sampled at block start |
| dataIn | input | 4 | Message nibble, bit 3 earliest |
| validOut | output | 1 | dataOut holds a codeword nibble |
| dataOut | output | 4 | Message nibble or parity nibble, bit 3 earliest |

## Verification
The checker watches several properties on every cycle. It checks that each accepted nibble is echoed on the next cycle, and that a parity phase never has holes in its output. It checks that gap cycles and stray idle nibbles stay silent, and that the latched rate stays fixed through a block. It also checks the source-side rules on start, valid and rate range. Whether the parity values are right, and whether whole codewords are divisible, can only be shown by the bench's scenarios. Those scenarios compare the output with a bit-serial long division on every clock and test divisibility by g(x) at the end of each block. They cover all three codes, gapped input, rate wiggling, repeated messages, and all-zero and single-bit messages.

// File: rtl/bchEncPkg.sv
package bchEncPkg;
  localparam int LANES       = 4;
  localparam int NUM_RATES   = 3;
  localparam int PAR_MAX     = 12;
  localparam int MSG_NIB_MAX = 12;
  localparam int RATE_W      = $clog2(NUM_RATES);
  localparam int CNT_W       = $clog2(MSG_NIB_MAX + 1);

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {PH_IDLE, PH_MSG, PH_PAR} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // restart remainder from zero
    logic absorb;  // take a message nibble
    logic emit;    // shift out a parity nibble
  } strobe_t;

  // generator polynomials, leading term included (products of minimal polynomials)
  function automatic logic [PAR_MAX:0] genPoly(rate_t r);
    case (r)
      0:       return 13'h0013;  // m1 over GF(16)
      1:       return 13'h01D1;  // m1*m3 over GF(16)
      default: return 13'h1539;  // m1*m3 over GF(64)
    endcase
  endfunction

  function automatic cnt_t parNib(rate_t r);
    case (r)
      0:       return cnt_t'(1);
      1:       return cnt_t'(2);
      default: return cnt_t'(3);
    endcase
  endfunction

  function automatic cnt_t msgNib(rate_t r);
    case (r)
      0:       return cnt_t'(2);
      1:       return cnt_t'(1);
      default: return cnt_t'(12);
    endcase
  endfunction
endpackage

// File: rtl/bchEncCtl.sv
module bchEncCtl
  import bchEncPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sopIn,
  input  logic    validIn,
  input  rate_t   rateIn,
  output strobe_t strobe,
  output rate_t   rateSel
);
  phase_t stateQ;
  cnt_t   cntQ;
  rate_t  rateQ;
  logic   startNow;

  assign startNow = (stateQ == PH_IDLE) && validIn && sopIn;
  assign rateSel  = startNow ? rateIn : rateQ;

  always_comb begin
    strobe.clear  = startNow;
    strobe.absorb = startNow || ((stateQ == PH_MSG) && validIn);
    strobe.emit   = (stateQ == PH_PAR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PH_IDLE;
      cntQ   <= '0;
      rateQ  <= '0;
    end else begin
      case (stateQ)
        PH_IDLE: if (startNow) begin
          rateQ <= rateIn;
          if (msgNib(rateIn) == cnt_t'(1)) begin
            stateQ <= PH_PAR;
            cntQ   <= parNib(rateIn);
          end else begin
            stateQ <= PH_MSG;
            cntQ   <= msgNib(rateIn) - cnt_t'(1);
          end
        end
        PH_MSG: if (validIn) begin
          if (cntQ == cnt_t'(1)) begin
            stateQ <= PH_PAR;
            cntQ   <= parNib(rateQ);
          end else begin
            cntQ <= cntQ - cnt_t'(1);
          end
        end
        PH_PAR: begin
          if (cntQ == cnt_t'(1)) begin
            stateQ <= PH_IDLE;
            cntQ   <= '0;
          end else begin
            cntQ <= cntQ - cnt_t'(1);
          end
        end
        default: stateQ <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bchEncDp.sv
module bchEncDp
  import bchEncPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  rate_t            rateSel,
  input  logic [LANES-1:0] dataIn,
  output logic             validOut,
  output logic [LANES-1:0] dataOut
);
  // remainder kept left-aligned: its top bit is always the feedback tap
  logic [PAR_MAX-1:0] remQ;
  logic [PAR_MAX-1:0] remNext;
  logic [PAR_MAX-1:0] genAligned;
  logic [PAR_MAX:0]   gShift;
  logic [PAR_MAX-1:0] acc;
  logic               fb;

  always_comb begin
    gShift     = genPoly(rateSel) << (PAR_MAX - LANES * int'(parNib(rateSel)));
    genAligned = gShift[PAR_MAX-1:0];
  end

  // four serial division steps unrolled into one cycle
  always_comb begin
    acc = strobe.clear ? '0 : remQ;
    fb  = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      fb  = dataIn[i] ^ acc[PAR_MAX-1];
      acc = {acc[PAR_MAX-2:0], 1'b0} ^ (fb ? genAligned : '0);
    end
    remNext = acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ     <= '0;
      dataOut  <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= strobe.absorb || strobe.emit;
      if (strobe.absorb) begin
        remQ    <= remNext;
        dataOut <= dataIn;
      end else if (strobe.emit) begin
        dataOut <= remQ[PAR_MAX-1 -: LANES];
        remQ    <= remQ << LANES;
      end
    end
  end
endmodule

// File: rtl/bchEnc.sv
module bchEnc
  import bchEncPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic              validIn,
  input  logic [RATE_W-1:0] rateIn,
  input  logic [LANES-1:0]  dataIn,
  output logic              validOut,
  output logic [LANES-1:0]  dataOut
);
  strobe_t strobe;
  rate_t   rateSel;

  bchEncCtl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .sopIn   (sopIn),
    .validIn (validIn),
    .rateIn  (rateIn),
    .strobe  (strobe),
    .rateSel (rateSel)
  );

  bchEncDp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rateSel  (rateSel),
    .dataIn   (dataIn),
    .validOut (validOut),
    .dataOut  (dataOut)
  );
endmodule

// File: rtl/bchEncChk.sv
module bchEncChk
  import bchEncPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sopIn,
  input logic              validIn,
  input logic [RATE_W-1:0] rateIn,
  input logic [LANES-1:0]  dataIn,
  input logic              validOut,
  input logic [LANES-1:0]  dataOut,
  input phase_t            phase,
  input rate_t             rateHeld
);
  // R2: accepted nibble echoed next cycle
  a_r2_echo: assert property (@(posedge clk) disable iff (!rstN)
    (((phase == PH_IDLE) && sopIn && validIn) || ((phase == PH_MSG) && validIn))
      |=> (validOut && (dataOut == $past(dataIn))));

  // R3: every parity cycle produces output
  a_r3_parity_solid: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PAR) |=> validOut);

  // R5: gap cycle inside a block is silent
  a_r5_gap_silent: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_MSG) && !validIn) |=> !validOut);

  // R6: latched rate fixed while a block is in flight
  a_r6_rate_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> $stable(rateHeld));

  // R8: stray idle nibble ignored
  a_r8_idle_ignore: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_IDLE) && validIn && !sopIn) |=> !validOut);

  // R10: source rules
  a_r10_quiet_parity: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PAR) |-> !validIn);

  a_r10_sop_idle: assert property (@(posedge clk) disable iff (!rstN)
    sopIn |-> ((phase == PH_IDLE) && validIn));

  // R1: only defined rate codes start a block
  a_r1_rate_range: assert property (@(posedge clk) disable iff (!rstN)
    (sopIn && validIn) |-> (int'(rateIn) < NUM_RATES));
endmodule

bind bchEnc bchEncChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sopIn    (sopIn),
  .validIn  (validIn),
  .rateIn   (rateIn),
  .dataIn   (dataIn),
  .validOut (validOut),
  .dataOut  (dataOut),
  .phase    (uCtl.stateQ),
  .rateHeld (uCtl.rateQ)
);

// File: tb/sim_bchEnc.sv
module sim_bchEnc;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sopIn = 1'b0;
  logic       validIn = 1'b0;
  logic [1:0] rateIn = '0;
  logic [3:0] dataIn = '0;
  logic       validOut;
  logic [3:0] dataOut;

  always #10 clk = ~clk;  // 50 MHz

  bchEnc u0 (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .validIn(validIn),
    .rateIn(rateIn), .dataIn(dataIn), .validOut(validOut), .dataOut(dataOut)
  );

  typedef struct {
    bit       v;
    bit [3:0] d;
    string    tag;
  } exp_t;

  exp_t expQ[$];
  bit   capBits[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;
  bit   rstReq = 1'b0;

  int gTab[3] = '{'h13, 'h1D1, 'h1539};
  int pTab[3] = '{4, 8, 12};
  int mTab[3] = '{2, 1, 12};

  // bit-serial long division, bits in order of descending power
  function automatic int polyMod(bit bits[$], int g, int p);
    int rem = 0;
    foreach (bits[k]) begin
      rem = (rem << 1) | int'(bits[k]);
      if (((rem >> p) & 1) == 1) rem = rem ^ g;
    end
    return rem;
  endfunction

  task automatic compareOut();
    exp_t e;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    checks++;
    if (validOut !== e.v || (e.v && dataOut !== e.d)) begin
      failures++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               e.tag, validOut, dataOut, e.v, e.d);
    end
    if (validOut === 1'b1)
      for (int b = 3; b >= 0; b--) capBits.push_back(dataOut[b]);
  endtask

  task automatic tick(bit v, bit s, int r, int d, bit ev, int ed, string tag);
    exp_t e;
    @(negedge clk);
    compareOut();
    rstN    = rstReq;
    validIn = v;
    sopIn   = s;
    rateIn  = 2'(r);
    dataIn  = 4'(d);
    e.v = ev; e.d = 4'(ed); e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendBlock(int r, int nibs[$], int gapEvery, bit wiggle, string parTag);
    bit msgBits[$];
    int p, rem, rr;
    p = pTab[r];
    capBits.delete();
    foreach (nibs[i]) for (int b = 3; b >= 0; b--) msgBits.push_back(bit'((nibs[i] >> b) & 1));
    for (int z = 0; z < p; z++) msgBits.push_back(1'b0);
    rem = polyMod(msgBits, gTab[r], p);
    foreach (nibs[i]) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0)
        tick(0, 0, r, 6, 0, 0, "R5");
      rr = (i > 0 && wiggle) ? ((r + i) % 4) : r;
      tick(1, i == 0, rr, nibs[i], 1, nibs[i], (i == 0) ? "R1" : (wiggle ? "R6" : "R2"));
    end
    for (int j = 0; j < p / 4; j++)
      tick(0, 0, 0, 0, 1, (rem >> (p - 4 * (j + 1))) & 15, parTag);
    tick(0, 0, 0, 0, 0, 0, "R3");
    // R4: whole captured codeword divisible by g(x)
    checks++;
    if (capBits.size() != 4 * nibs.size() + p || polyMod(capBits, gTab[r], p) != 0) begin
      failures++;
      $display("FAIL R4: codeword bits=%0d remainder=%h, expected bits=%0d remainder=0",
               capBits.size(), polyMod(capBits, gTab[r], p), 4 * nibs.size() + p);
    end
  endtask

  initial begin
    int big[$];
    rstReq = 1'b0;
    repeat (3) tick(0, 0, 0, 0, 0, 0, "R9");
    rstReq = 1'b1;
    tick(0, 0, 0, 0, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, 0, "R9");
    // R8: stray nibbles while idle
    tick(1, 0, 0, 15, 0, 0, "R8");
    tick(1, 0, 2, 9, 0, 0, "R8");
    sendBlock(0, '{10, 5}, 0, 0, "R3");
    sendBlock(0, '{10, 5}, 0, 0, "R7");
    sendBlock(1, '{9}, 0, 0, "R3");
    big.delete();
    for (int i = 0; i < 12; i++) big.push_back((i * 7 + 3) & 15);
    sendBlock(2, big, 3, 0, "R3");
    big.delete();
    for (int i = 0; i < 12; i++) big.push_back(15);
    sendBlock(2, big, 0, 1, "R3");
    sendBlock(1, '{0}, 0, 0, "R3");
    sendBlock(0, '{8, 0}, 2, 1, "R3");
    big.delete();
    for (int i = 0; i < 12; i++) big.push_back(i == 11 ? 1 : 0);
    sendBlock(2, big, 5, 0, "R3");
    tick(1, 0, 1, 3, 0, 0, "R8");
    tick(0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk);
    compareOut();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule